// File: doc/BRIEF.md
# Configurable Serial Port with Threshold Interrupts

This block is an asynchronous serial transmitter and receiver behind a small register bus. Software pushes bytes into a transmit queue and pops them from a receive queue. It chooses the character format at run time: 5 to 8 data bits, none, even or odd parity, and one or two stop bits. The bit clock comes from the system (crystal) clock. That clock is first divided by three and then by a programmable divisor plus one.

A single level-sensitive interrupt line reports two conditions, each with its own enable: the transmit queue has drained below a programmed level, or the receive queue has filled to a programmed level. An optional request-to-send / clear-to-send handshake throttles both directions. The request-to-send pin can be inverted so that the far end is held off while the port is being set up. Separate reset bits flush each queue and clear the sticky error flags.

Top module: `serial_port`

## Requirements
- R1: After reset `txd` is 1, `irq` is 0 and `rts` is 1. STATUS (address 3) reads 0x0001, and CONTROL (address 2) reads 0x0003, which selects 8 data bits with every enable clear.
- R2: A frame on `txd` is one low start bit, then the data bits LSB first, then an optional parity bit, then the high stop bit or bits. Every bit lasts 3*(d+1) clock cycles. d is the divisor in BAUD (address 5) bits [DIVW-1:0] when both bit 14 (crystal select) and bit 15 (new-divisor enable) are set; otherwise d is DEF_DIV.
- R3: CONTROL bits [4:3] select parity: 0 none, 1 even, 2 odd, 3 none. The receiver sets the sticky STATUS bit 2 when the received parity bit does not match, and it still stores the byte.
- R4: CONTROL bits [1:0] select 5, 6, 7 or 8 data bits (codes 0 to 3), and bit 2 selects two stop bits. A low first stop bit at the receiver sets the sticky STATUS bit 3, and the byte is still stored.
- R5: When a byte completes while the receive queue is full, the byte is discarded and the sticky STATUS bit 4 is set.
- R6: A write to address 0 pushes one byte into the transmit queue, and a write to a full transmit queue is ignored. A read of address 1 returns the oldest received byte and pops it. Read data appears on `bus_rdata` in the cycle after `bus_rd`. STATUS bit 0 is receive-queue-empty and bit 1 is transmit-queue-full.
- R7: CONTROL bit 11 flushes the receive queue, bit 12 flushes the transmit queue and bit 13 clears STATUS bits 2 to 4, each for as long as it is held at 1.
- R8: CONTROL bit 6 enables transmission and bit 7 enables reception. With bit 6 clear, no frame starts. With bit 7 clear, incoming frames are not stored.
- R9: With CONTROL bit 5 (two-wire mode) clear, the handshake is active. No new frame starts while `cts` is 0, and `rts` goes to 0 while the receive queue is full. With bit 5 set, `cts` is ignored and `rts` stays 1.
- R10: CONTROL bit 10 inverts the `rts` output.
- R11: MISC (address 4) holds the transmit threshold in bits [7:0] and the receive threshold in bits [15:8]. `irq` is 1 when either of two conditions holds: CONTROL bit 8 is set and transmit occupancy is below its threshold, or CONTROL bit 9 is set and receive occupancy is at or above its threshold. `irq` follows these conditions one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts | input | 1 | Clear-to-send from the far end, 1 = may send |
| rts | output | 1 | Request-to-send to the far end, 1 = ready (before inversion) |
| irq | output | 1 | Level interrupt |

## Verification
The bench runs every character format in loopback. A width decode that was off by one, or parity of the wrong sense, would show up as a corrupted byte or a spurious parity flag. It measures the start-bit width with and without the divisor enables, which catches a divisor missing its pre-division by three or applied when it should not be. It fills the transmit queue beyond its depth and the receive queue into overrun. A queue that accepted the extra write, or one that kept the late byte, would return a fifth byte or the wrong fourth one. It also holds `cts` low and steps the interrupt thresholds across their boundaries, so that a comparison that was strict where it should be inclusive, or a transmitter that ignored `cts`, changes `irq` or `txd` at a visible point.

// File: rtl/serial_pkg.sv
package serial_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSVD = 2'd3
  } parity_e;

  typedef struct packed {
    logic    clr_err;
    logic    rst_tx;
    logic    rst_rx;
    logic    inv_rts;
    logic    rx_ie;
    logic    tx_ie;
    logic    rx_en;
    logic    tx_en;
    logic    two_wire;
    parity_e par;
    logic    stop2;
    logic [1:0] len;
  } ctrl_t;

  localparam logic [2:0] A_TXD  = 3'd0;
  localparam logic [2:0] A_RXD  = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_MISC = 3'd4;
  localparam logic [2:0] A_BAUD = 3'd5;

endpackage

// File: rtl/serial_fifo.sv
module serial_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= wp + AW'(1);
      if (pop_ok)  rp <= rp + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  // R6
  full_push_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> level == $past(level));

endmodule

// File: rtl/serial_tx.sv
module serial_tx import serial_pkg::*; #(
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          en,
  input  logic [1:0]    len,
  input  logic          stop2,
  input  parity_e       par,
  input  logic          fc_on,
  input  logic          cts,
  input  logic [PW-1:0] period,
  input  logic          q_empty,
  input  logic [7:0]    q_data,
  output logic          q_pop,
  output logic          txd
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_e;

  tx_st_e        st;
  logic [PW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    bi;
  logic          acc, s2nd;
  logic [3:0]    nb;
  logic          par_on, bit_end;

  assign nb      = 4'd5 + {2'b00, len};
  assign par_on  = (par == PAR_EVEN) || (par == PAR_ODD);
  assign bit_end = (cnt == '0);
  assign q_pop   = (st == T_IDLE) && en && !q_empty && (!fc_on || cts) && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st   <= T_IDLE;
      txd  <= 1'b1;
      cnt  <= '0;
      sh   <= '0;
      bi   <= '0;
      acc  <= 1'b0;
      s2nd <= 1'b0;
    end else if (st == T_IDLE) begin
      if (q_pop) begin
        st  <= T_START;
        txd <= 1'b0;
        cnt <= period - PW'(1);
        sh  <= q_data;
      end
    end else if (!bit_end) begin
      cnt <= cnt - PW'(1);
    end else begin
      cnt <= period - PW'(1);
      case (st)
        T_START: begin
          txd <= sh[0];
          acc <= sh[0];
          sh  <= sh >> 1;
          bi  <= '0;
          st  <= T_DATA;
        end
        T_DATA: begin
          if ({1'b0, bi} == nb - 4'd1) begin
            if (par_on) begin
              txd <= (par == PAR_ODD) ? ~acc : acc;
              st  <= T_PAR;
            end else begin
              txd  <= 1'b1;
              s2nd <= 1'b0;
              st   <= T_STOP;
            end
          end else begin
            bi  <= bi + 3'd1;
            txd <= sh[0];
            acc <= acc ^ sh[0];
            sh  <= sh >> 1;
          end
        end
        T_PAR: begin
          txd  <= 1'b1;
          s2nd <= 1'b0;
          st   <= T_STOP;
        end
        default: begin
          if (stop2 && !s2nd) s2nd <= 1'b1;
          else                st   <= T_IDLE;
        end
      endcase
    end
  end

  // R9
  cts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == T_IDLE && fc_on && !cts) |=> st == T_IDLE);

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (st == T_IDLE) |-> txd);

endmodule

// File: rtl/serial_rx.sv
module serial_rx import serial_pkg::*; #(
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          en,
  input  logic [1:0]    len,
  input  parity_e       par,
  input  logic [PW-1:0] period,
  input  logic          rxd,
  output logic          push,
  output logic [7:0]    data,
  output logic          perr,
  output logic          ferr
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_st_e;

  rx_st_e        st;
  logic [PW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    bi;
  logic          acc, pbad;
  logic          s_meta, s_line, s_prev;
  logic [3:0]    nb;
  logic          par_on, bit_end, fall;

  assign nb      = 4'd5 + {2'b00, len};
  assign par_on  = (par == PAR_EVEN) || (par == PAR_ODD);
  assign bit_end = (cnt == '0);
  assign fall    = s_prev && !s_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_meta <= 1'b1;
      s_line <= 1'b1;
      s_prev <= 1'b1;
    end else begin
      s_meta <= rxd;
      s_line <= s_meta;
      s_prev <= s_line;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st   <= R_IDLE;
      cnt  <= '0;
      sh   <= '0;
      bi   <= '0;
      acc  <= 1'b0;
      pbad <= 1'b0;
      push <= 1'b0;
      data <= '0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      push <= 1'b0;
      if (st == R_IDLE) begin
        if (en && fall) begin
          st  <= R_START;
          cnt <= period >> 1;
        end
      end else if (!bit_end) begin
        cnt <= cnt - PW'(1);
      end else begin
        cnt <= period - PW'(1);
        case (st)
          R_START: begin
            bi   <= '0;
            acc  <= 1'b0;
            pbad <= 1'b0;
            st   <= s_line ? R_IDLE : R_DATA;
          end
          R_DATA: begin
            sh  <= {s_line, sh[7:1]};
            acc <= acc ^ s_line;
            if ({1'b0, bi} == nb - 4'd1) st <= par_on ? R_PAR : R_STOP;
            else                         bi <= bi + 3'd1;
          end
          R_PAR: begin
            pbad <= s_line != ((par == PAR_ODD) ? ~acc : acc);
            st   <= R_STOP;
          end
          default: begin
            push <= 1'b1;
            data <= sh >> (4'd8 - nb);
            perr <= pbad;
            ferr <= !s_line;
            st   <= R_IDLE;
          end
        endcase
      end
    end
  end

  // R4
  push_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(st == R_STOP));

endmodule

// File: rtl/serial_port.sv
module serial_port import serial_pkg::*; #(
  parameter int DEPTH   = 16,
  parameter int DIVW    = 12,
  parameter int DEF_DIV = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        txd,
  input  logic        rxd,
  input  logic        cts,
  output logic        rts,
  output logic        irq
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam int PW = DIVW + 2;

  ctrl_t          ctrl_q;
  logic [7:0]     tx_thr, rx_thr;
  logic [DIVW-1:0] div_q, div_eff;
  logic           use_xtal, use_new;
  logic           perr_q, ferr_q, ovr_q;
  logic [PW-1:0]  period;

  logic           tx_push, tx_pop, tx_empty, tx_full;
  logic [7:0]     tx_head;
  logic [LW-1:0]  tx_lvl;
  logic           rx_pop, rx_push, rx_empty, rx_full, rx_perr, rx_ferr;
  logic [7:0]     rx_head, rx_byte;
  logic [LW-1:0]  rx_lvl;

  assign tx_push = bus_wr && (bus_addr == A_TXD);
  assign rx_pop  = bus_rd && (bus_addr == A_RXD) && !rx_empty;
  assign div_eff = (use_xtal && use_new) ? div_q : DIVW'(DEF_DIV);
  assign period  = PW'(div_eff) * PW'(3) + PW'(3);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= ctrl_t'(14'h0003);
      tx_thr   <= 8'(DEPTH / 2);
      rx_thr   <= 8'd1;
      div_q    <= DIVW'(DEF_DIV);
      use_xtal <= 1'b0;
      use_new  <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: ctrl_q <= ctrl_t'(bus_wdata[13:0]);
        A_MISC: begin
          tx_thr <= bus_wdata[7:0];
          rx_thr <= bus_wdata[15:8];
        end
        A_BAUD: begin
          div_q    <= bus_wdata[DIVW-1:0];
          use_xtal <= bus_wdata[14];
          use_new  <= bus_wdata[15];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (ctrl_q.clr_err) begin
        perr_q <= 1'b0;
        ferr_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (rx_push && rx_perr) perr_q <= 1'b1;
      if (rx_push && rx_ferr) ferr_q <= 1'b1;
      if (rx_push && rx_full) ovr_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_RXD:   bus_rdata <= {8'd0, rx_head};
        A_CTRL:  bus_rdata <= {2'd0, ctrl_q};
        A_STAT:  bus_rdata <= {11'd0, ovr_q, ferr_q, perr_q, tx_full, rx_empty};
        A_MISC:  bus_rdata <= {rx_thr, tx_thr};
        A_BAUD:  bus_rdata <= {use_new, use_xtal, 14'(div_q)};
        default: bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rts <= 1'b1;
      irq <= 1'b0;
    end else begin
      rts <= (ctrl_q.two_wire | ~rx_full) ^ ctrl_q.inv_rts;
      irq <= (ctrl_q.tx_ie && (8'(tx_lvl) <  tx_thr)) ||
             (ctrl_q.rx_ie && (8'(rx_lvl) >= rx_thr));
    end
  end

  serial_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(ctrl_q.rst_tx),
    .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_head),
    .level(tx_lvl), .empty(tx_empty), .full(tx_full)
  );

  serial_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(ctrl_q.rst_rx),
    .push(rx_push), .din(rx_byte), .pop(rx_pop), .dout(rx_head),
    .level(rx_lvl), .empty(rx_empty), .full(rx_full)
  );

  serial_tx #(.PW(PW)) u_tx (
    .clk(clk), .rst(rst), .flush(ctrl_q.rst_tx), .en(ctrl_q.tx_en),
    .len(ctrl_q.len), .stop2(ctrl_q.stop2), .par(ctrl_q.par),
    .fc_on(!ctrl_q.two_wire), .cts(cts), .period(period),
    .q_empty(tx_empty), .q_data(tx_head), .q_pop(tx_pop), .txd(txd)
  );

  serial_rx #(.PW(PW)) u_rx (
    .clk(clk), .rst(rst), .flush(ctrl_q.rst_rx), .en(ctrl_q.rx_en),
    .len(ctrl_q.len), .par(ctrl_q.par), .period(period), .rxd(rxd),
    .push(rx_push), .data(rx_byte), .perr(rx_perr), .ferr(rx_ferr)
  );

  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full) |=> ovr_q);

  // R9
  rts_full_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.two_wire && !ctrl_q.inv_rts && rx_full) |=> !rts);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctrl_q.tx_ie || ctrl_q.rx_ie));

  // R7
  rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.rst_rx |=> rx_empty);

endmodule

// File: tb/serial_port_test.sv
`timescale 1ns/1ps
module serial_port_test;
  localparam logic [15:0] TWO = 16'h0020, TXE = 16'h0040, RXE = 16'h0080;
  localparam logic [15:0] TIE = 16'h0100, RIE = 16'h0200, INV = 16'h0400;
  localparam logic [15:0] RRX = 16'h0800, RTX = 16'h1000, CLR = 16'h2000;
  localparam logic [15:0] L8  = 16'h0003, EVN = 16'h0008;
  // {cfg[20:16] = par,stop2,len ; byte[15:8] ; expected[7:0]}
  localparam logic [23:0] VEC [6] = '{
    24'h03A5A5, 24'h083F1F, 24'h15C707, 24'h0EFF7F, 24'h135A5A, 24'h0F0000
  };

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic txd, rxd_w, cts = 1'b1, rts, irq;
  logic loop_en = 1'b0, rx_drv = 1'b1;
  logic [15:0] rd;
  logic [23:0] v;
  int n_chk = 0, n_err = 0, w;

  always #2.5 clk = ~clk;
  assign rxd_w = loop_en ? txd : rx_drv;

  serial_port #(.DEPTH(4), .DIVW(8), .DEF_DIV(1)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd_w),
    .cts(cts), .rts(rts), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic send_bit(input logic b);
    rx_drv = b;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input int pm,
                            input bit bad_par, input bit bad_stop);
    logic p;
    p = 1'b0;
    send_bit(1'b0);
    for (int k = 0; k < nb; k++) begin
      send_bit(d[k]);
      p = p ^ d[k];
    end
    if (pm != 0) send_bit(((pm == 2) ? ~p : p) ^ bad_par);
    send_bit(!bad_stop);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic count_low(input int n, output int lows);
    lows = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (txd === 1'b0) lows++;
    end
  endtask

  task automatic start_width(output int wd);
    int t;
    t = 0;
    while (txd !== 1'b0 && t < 50) begin @(negedge clk); t++; end
    wd = 0;
    while (txd === 1'b0 && wd < 100) begin wd++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    check("R1 txd", txd, 1);
    check("R1 irq", irq, 0);
    check("R1 rts", rts, 1);
    bus_read(3'd3, rd); check("R1 status", rd, 16'h0001);
    bus_read(3'd2, rd); check("R1 control", rd, 16'h0003);

    // R2 R3 R4: formats in loopback, walked from the vector table
    loop_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      bus_write(3'd2, TXE | RXE | TWO | {11'd0, v[20:16]});
      bus_write(3'd0, {8'd0, v[15:8]});
      idle(120);
      bus_read(3'd3, rd); check("R4 loopback status", rd, 16'h0000);
      bus_read(3'd1, rd); check("R2 loopback byte", rd, {8'd0, v[7:0]});
    end

    // R2 bit period: enabled divisor 2 gives 9 cycles
    bus_write(3'd2, TWO | TXE | L8);
    bus_write(3'd5, 16'hC002);
    bus_write(3'd0, 16'h0001);
    start_width(w); check("R2 period enabled", w, 9);
    idle(100);
    bus_write(3'd5, 16'h0002);
    bus_write(3'd0, 16'h0001);
    start_width(w); check("R2 period default", w, 6);
    idle(80);

    // R6 queue full, extra write ignored
    bus_write(3'd2, TWO | RRX | RTX | L8);
    bus_write(3'd2, TWO | L8);
    bus_write(3'd0, 16'h0011); bus_write(3'd0, 16'h0022);
    bus_write(3'd0, 16'h0033); bus_write(3'd0, 16'h0044);
    bus_read(3'd3, rd); check("R6 tx full", rd, 16'h0003);
    bus_write(3'd0, 16'h0055);
    bus_write(3'd2, TWO | TXE | RXE | L8);
    idle(320);
    bus_read(3'd1, rd); check("R6 pop 1", rd, 16'h0011);
    bus_read(3'd1, rd); check("R6 pop 2", rd, 16'h0022);
    bus_read(3'd1, rd); check("R6 pop 3", rd, 16'h0033);
    bus_read(3'd1, rd); check("R6 pop 4", rd, 16'h0044);
    bus_read(3'd3, rd); check("R6 drained, fifth ignored", rd, 16'h0001);

    // R3 parity error, R7 clear and flush
    loop_en = 1'b0;
    bus_write(3'd2, TWO | RXE | L8 | EVN);
    send_frame(8'h03, 8, 1, 1'b1, 1'b0);
    bus_read(3'd3, rd); check("R3 parity error", rd, 16'h0004);
    bus_write(3'd2, TWO | RXE | L8 | EVN | CLR);
    bus_write(3'd2, TWO | RXE | L8 | EVN);
    bus_read(3'd3, rd); check("R7 error clear", rd, 16'h0000);
    bus_write(3'd2, TWO | RXE | L8 | EVN | RRX);
    bus_write(3'd2, TWO | RXE | L8 | EVN);
    bus_read(3'd3, rd); check("R7 rx flush", rd, 16'h0001);
    send_frame(8'h03, 8, 1, 1'b0, 1'b0);
    bus_read(3'd3, rd); check("R3 parity good", rd, 16'h0000);
    bus_read(3'd1, rd); check("R3 parity byte", rd, 16'h0003);

    // R4 framing error
    bus_write(3'd2, TWO | RXE | L8);
    send_frame(8'hF0, 8, 0, 1'b0, 1'b1);
    bus_read(3'd3, rd); check("R4 framing error", rd, 16'h0008);
    bus_read(3'd1, rd); check("R4 framing byte kept", rd, 16'h00F0);
    bus_write(3'd2, TWO | L8 | CLR | RRX);

    // R8 enables
    bus_write(3'd2, TWO | L8);
    send_frame(8'h81, 8, 0, 1'b0, 1'b0);
    bus_read(3'd3, rd); check("R8 rx disabled", rd, 16'h0001);
    bus_write(3'd0, 16'h0000);
    count_low(100, w); check("R8 tx disabled", w, 0);
    bus_write(3'd2, TWO | L8 | RTX);
    bus_write(3'd2, TWO | TXE | L8);
    count_low(100, w); check("R7 tx flush", w, 0);

    // R5 overrun, R9 rts, R10 inversion
    bus_write(3'd2, RXE | L8);
    for (int i = 0; i < 5; i++) send_frame(8'hA1 + 8'(i), 8, 0, 1'b0, 1'b0);
    bus_read(3'd3, rd); check("R5 overrun flag", rd, 16'h0010);
    check("R9 rts low when full", rts, 0);
    bus_write(3'd2, RXE | L8 | INV);
    idle(2); check("R10 rts inverted full", rts, 1);
    bus_read(3'd1, rd); check("R5 first byte", rd, 16'h00A1);
    bus_read(3'd1, rd); bus_read(3'd1, rd);
    bus_read(3'd1, rd); check("R5 fourth byte kept", rd, 16'h00A4);
    bus_read(3'd3, rd); check("R5 late byte dropped", rd, 16'h0011);
    idle(2); check("R10 rts inverted ready", rts, 0);
    bus_write(3'd2, RXE | L8 | CLR);
    bus_write(3'd2, L8);
    idle(2); check("R9 rts ready", rts, 1);

    // R9 cts hold
    cts = 1'b0;
    bus_write(3'd2, TXE | L8);
    bus_write(3'd0, 16'h0055);
    count_low(100, w); check("R9 cts holds tx", w, 0);
    cts = 1'b1;
    count_low(20, w); check("R9 cts release starts", (w > 0), 1);
    idle(100);

    // R11 interrupt thresholds
    bus_write(3'd2, TWO | L8 | RRX | RTX);
    bus_write(3'd4, 16'h0102);
    bus_write(3'd2, TWO | TIE | L8);
    idle(3); check("R11 tx below threshold", irq, 1);
    bus_write(3'd0, 16'h0001);
    idle(3); check("R11 tx one below", irq, 1);
    bus_write(3'd0, 16'h0002);
    idle(3); check("R11 tx at threshold", irq, 0);
    bus_write(3'd2, TWO | RTX | L8);
    bus_write(3'd2, TWO | RXE | RIE | L8);
    idle(3); check("R11 rx empty", irq, 0);
    send_frame(8'h3C, 8, 0, 1'b0, 1'b0);
    check("R11 rx at threshold", irq, 1);
    bus_read(3'd1, rd);
    idle(3); check("R11 rx drained", irq, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule